// File: doc/BRIEF.md
# Interleaved DRAM Nibble Access Sequencer

This block drives a DRAM array that is four bits wide and turns each memory slot of eight phase-clock cycles into one byte access. Within a slot the row strobe falls once and the column strobe falls twice. The two column addresses differ only in a nibble-select bit, so one byte is built from a low nibble and a high nibble read back to back in page mode. Writes use the same two strobes, with the write data split into two nibbles.

Two requesters compete for slots: a video fetch port and a CPU port. A two-bit share mode decides how they divide the slots, which also sets the rate of the CPU clock enable.
- In CPU-only mode the CPU has every slot, and the enable pulses once per slot (2 MHz at a 16 MHz phase clock).
- In shared mode video takes alternate slots while it requests, so the CPU runs at half rate.
- In video-full mode video takes every slot while it requests, and the CPU clock stops.

Top module: `dram_nibble_seq`

## Requirements
- R1: While rst_n is low and in the first cycle after it, ras_n, cas_n and dram_we_n are high, cpu_valid, vid_valid and dram_dq_oe are low, and slot_phase is 0.
- R2: A slot is eight cycles, with slot_phase counting 0 to 7. In a slot owned by a requester, ras_n is low in phases 1 to 5 and cas_n is low in phases 3 and 5 only. A slot with no owner produces no strobe.
- R3: dram_a carries the row, address bits [15:8], in phases 0 and 1. It carries the column {address[7:0], 0} in phases 2 and 3 and {address[7:0], 1} in phases 4 to 7. The address is unchanged in the cycle before each strobe falls.
- R4: In a read slot the nibble taken under the first column strobe becomes rd_data[3:0] and the nibble taken under the second becomes rd_data[7:4]. The owner's valid pulses in phase 6 of the slot.
- R5: A CPU write (cpu_rnw = 0) holds dram_we_n low and dram_dq_oe high in phases 2 to 5. dram_dq_out is cpu_wdata[3:0] in phases 2 and 3 and cpu_wdata[7:4] in phases 4 and 5. cpu_valid acknowledges the write, and no other byte changes.
- R6: With mode = 0 (CPU only), every slot is open to the CPU, vid_req has no effect, and cpu_ce pulses in phase 7 of every slot.
- R7: With mode = 1 (shared) and vid_req high, video owns the even slots and the CPU the odd slots, counting from slot 0 after reset. cpu_ce pulses only in phase 7 before an odd slot.
- R8: With mode = 2 or 3 (video full) and vid_req high, video owns every slot, cpu_ce stays low, and a pending CPU request waits.
- R9: In modes 1 to 3 with vid_req low, every slot is open to the CPU and cpu_ce pulses once per slot, whether or not the CPU requests.
- R10: Requests, addresses, cpu_rnw and cpu_wdata are sampled at the end of phase 7 for the next slot. A requester holds its request until its valid. When both are eligible, video wins.
- R11: cpu_valid and vid_valid are never high together, and each lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, eight cycles per slot |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Share mode: 0 CPU only, 1 shared, 2/3 video full |
| vid_req | input | 1 | Video fetch request |
| vid_addr | input | 16 | Video byte address |
| cpu_req | input | 1 | CPU access request |
| cpu_rnw | input | 1 | 1 read, 0 write |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_ce | output | 1 | CPU clock enable, phase 7 only |
| cpu_valid | output | 1 | CPU slot completed |
| vid_valid | output | 1 | Video byte ready |
| rd_data | output | 8 | Assembled read byte |
| slot_phase | output | 3 | Current phase within the slot |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| dram_a | output | 9 | Multiplexed row/column address |
| dram_we_n | output | 1 | Write enable, low for write |
| dram_dq_out | output | 4 | Write nibble |
| dram_dq_oe | output | 1 | Write nibble drive enable |
| dram_dq_in | input | 4 | Read nibble from the array |

## Verification
The CPU clock enable and the slot arbitration act on the same phase-7 edge. Whether cpu_ce fires depends on whether video claims the next slot in that same cycle. The bench holds both requests high in every share mode, counts enables, CPU completions and video completions over an aligned window of eight slots, and compares the counts with the share rule. A checker property also ties each enable to the absence of a video completion seven cycles later. Reads and writes are judged against a nibble-wide DRAM model in the bench, which decodes row and column from the strobes alone.

// File: rtl/dram_nibble_seq.sv
module dram_nibble_seq #(
  parameter int ADDR_W = 16,
  parameter int ROW_W  = 8,
  parameter int NIB_W  = 4,
  localparam int DATA_W = 2 * NIB_W,
  localparam int COL_W  = ADDR_W - ROW_W + 1,
  localparam int DA_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              vid_req,
  input  logic [ADDR_W-1:0] vid_addr,
  input  logic              cpu_req,
  input  logic              cpu_rnw,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ce,
  output logic              cpu_valid,
  output logic              vid_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [2:0]        slot_phase,
  output logic              ras_n,
  output logic              cas_n,
  output logic [DA_W-1:0]   dram_a,
  output logic              dram_we_n,
  output logic [NIB_W-1:0]  dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [NIB_W-1:0]  dram_dq_in
);
  timeunit 1ns; timeprecision 1ps;

  typedef enum logic [1:0] {OWN_NONE, OWN_CPU, OWN_VID} owner_t;

  logic [2:0]        ph;
  logic              odd_q;
  owner_t            own_q;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;
  logic [DATA_W-1:0] wd_q;
  logic [NIB_W-1:0]  lo_q;

  logic vid_turn, grant_vid, act, slot_end;

  assign slot_end  = (ph == 3'd7);
  assign vid_turn  = (mode == 2'd1) ? odd_q : mode[1];
  assign grant_vid = vid_req && vid_turn;
  assign cpu_ce    = slot_end && !grant_vid;
  assign act       = (own_q != OWN_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= '0;
      odd_q     <= 1'b0;
      own_q     <= OWN_NONE;
      addr_q    <= '0;
      wr_q      <= 1'b0;
      wd_q      <= '0;
      lo_q      <= '0;
      rd_data   <= '0;
      cpu_valid <= 1'b0;
      vid_valid <= 1'b0;
    end else begin
      ph <= ph + 3'd1;
      if (slot_end) begin
        odd_q  <= ~odd_q;
        own_q  <= grant_vid ? OWN_VID : (cpu_req ? OWN_CPU : OWN_NONE);
        addr_q <= grant_vid ? vid_addr : cpu_addr;
        wr_q   <= !grant_vid && cpu_req && !cpu_rnw;
        wd_q   <= cpu_wdata;
      end
      if (ph == 3'd3) lo_q <= dram_dq_in;
      if (ph == 3'd5 && act && !wr_q) rd_data <= {dram_dq_in, lo_q};
      cpu_valid <= (ph == 3'd5) && (own_q == OWN_CPU);
      vid_valid <= (ph == 3'd5) && (own_q == OWN_VID);
    end
  end

  logic [ROW_W-1:0]  row_w;
  logic [COL_W-2:0]  col_w;

  assign row_w       = addr_q[ADDR_W-1 -: ROW_W];
  assign col_w       = addr_q[COL_W-2:0];
  assign slot_phase  = ph;
  assign ras_n       = !(act && ph >= 3'd1 && ph <= 3'd5);
  assign cas_n       = !(act && (ph == 3'd3 || ph == 3'd5));
  assign dram_a      = (ph < 3'd2) ? DA_W'(row_w) : DA_W'({col_w, ph[2]});
  assign dram_we_n   = !(act && wr_q && ph >= 3'd2 && ph <= 3'd5);
  assign dram_dq_oe  = !dram_we_n;
  assign dram_dq_out = ph[2] ? wd_q[DATA_W-1:NIB_W] : wd_q[NIB_W-1:0];
endmodule

module dram_nibble_seq_chk #(
  parameter int DA_W = 9
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ras_n,
  input logic            cas_n,
  input logic [DA_W-1:0] dram_a,
  input logic            dram_we_n,
  input logic            cpu_valid,
  input logic            vid_valid,
  input logic            cpu_ce,
  input logic [2:0]      slot_phase
);
  timeunit 1ns; timeprecision 1ps;

  assert_strobe_nest_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);
  assert_two_cas_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> ##2 $fell(cas_n) ##2 $fell(cas_n));
  assert_row_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $stable(dram_a));
  assert_col_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> $stable(dram_a));
  assert_valid_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid || vid_valid) |-> slot_phase == 3'd6);
  assert_we_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_we_n |-> !ras_n);
  assert_ce_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ce |-> slot_phase == 3'd7);
  assert_ce_no_video_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ce |-> ##7 !vid_valid);
  assert_valid_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_valid && vid_valid));
  assert_valid_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid || vid_valid) |=> !(cpu_valid || vid_valid));
endmodule

bind dram_nibble_seq dram_nibble_seq_chk #(.DA_W(DA_W)) u_chk (.*);

// File: tb/tb_dram_nibble_seq.sv
module tb_dram_nibble_seq;
  timeunit 1ns; timeprecision 1ps;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic vid_req = 1'b0, cpu_req = 1'b0, cpu_rnw = 1'b1;
  logic [15:0] vid_addr = '0, cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic cpu_ce, cpu_valid, vid_valid, ras_n, cas_n, dram_we_n, dram_dq_oe;
  logic [7:0] rd_data;
  logic [2:0] slot_phase;
  logic [8:0] dram_a;
  logic [3:0] dram_dq_out, dram_dq_in;

  int checks = 0, fails = 0;
  int ras_cnt = 0, cas_cnt = 0, we_cyc = 0;

  always #2.5 clk = ~clk;

  dram_nibble_seq dut (.*);

  logic [3:0] wmem [int];
  logic [7:0] row_l;
  logic [3:0] rd_nib = '0;

  function automatic logic [3:0] nib_at(int k);
    if (wmem.exists(k)) return wmem[k];
    return 4'((k * 5) ^ (k >> 4) ^ (k >> 9));
  endfunction

  function automatic logic [7:0] exp_byte(logic [15:0] a);
    return {nib_at(int'({a, 1'b1})), nib_at(int'({a, 1'b0}))};
  endfunction

  always @(negedge ras_n) begin
    row_l = dram_a[7:0];
    ras_cnt++;
  end

  always @(negedge cas_n) begin
    int k;
    k = int'({row_l, dram_a});
    if (!dram_we_n) wmem[k] = dram_dq_out;
    rd_nib = nib_at(k);
    cas_cnt++;
  end

  assign dram_dq_in = rd_nib;

  always @(negedge clk) if (!dram_we_n) we_cyc++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(ras_n && cas_n && dram_we_n, "R1 strobes", {ras_n, cas_n, dram_we_n}, 3'b111);
    chk(!cpu_valid && !vid_valid && !dram_dq_oe, "R1 valids", {cpu_valid, vid_valid, dram_dq_oe}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(slot_phase == 3'd1 && ras_n, "R1 first cycle", slot_phase, 1);
  endtask

  task automatic cpu_access(input logic [15:0] a, input logic rnw, input logic [7:0] wd,
                            output logic [7:0] rd, output int n);
    @(negedge clk);
    cpu_addr = a; cpu_rnw = rnw; cpu_wdata = wd; cpu_req = 1'b1;
    ras_cnt = 0; cas_cnt = 0; we_cyc = 0; n = 0;
    do begin @(negedge clk); n++; end while (!cpu_valid && n < 200);
    rd = rd_data;
    cpu_req = 1'b0;
  endtask

  task automatic t_read(input logic [15:0] a);
    logic [7:0] rd; int n;
    mode = 2'd0; vid_req = 1'b0;
    cpu_access(a, 1'b1, 8'h00, rd, n);
    chk(n < 200, "R10 read completes", n, 0);
    chk(rd == exp_byte(a), "R4 read byte", rd, exp_byte(a));
    chk(ras_cnt == 1 && cas_cnt == 2, "R2 strobe count", ras_cnt * 16 + cas_cnt, 8'h12);
    chk(we_cyc == 0, "R5 no write on read", we_cyc, 0);
  endtask

  task automatic t_write(input logic [15:0] a, input logic [7:0] d);
    logic [7:0] rd, nb; int n;
    mode = 2'd0; vid_req = 1'b0;
    nb = exp_byte(a + 16'd1);
    cpu_access(a, 1'b0, d, rd, n);
    chk(we_cyc == 4, "R5 write window", we_cyc, 4);
    chk(nib_at(int'({a, 1'b0})) == d[3:0] && nib_at(int'({a, 1'b1})) == d[7:4],
        "R3 column split", {nib_at(int'({a, 1'b1})), nib_at(int'({a, 1'b0}))}, d);
    cpu_access(a, 1'b1, 8'h00, rd, n);
    chk(rd == d, "R5 readback", rd, d);
    cpu_access(a + 16'd1, 1'b1, 8'h00, rd, n);
    chk(rd == nb, "R5 neighbour intact", rd, nb);
  endtask

  task automatic window(input logic [1:0] m, input logic vr, input logic cr,
                        input int e_cpu, input int e_vid, input int e_ce, input string req);
    int nc, nv, ne;
    @(negedge clk);
    mode = m; vid_req = vr; cpu_req = cr; cpu_rnw = 1'b1;
    vid_addr = 16'h4321; cpu_addr = 16'h0abc;
    do @(negedge clk); while (slot_phase != 3'd7);
    do @(negedge clk); while (slot_phase != 3'd0);
    nc = 0; nv = 0; ne = 0;
    for (int i = 0; i < 64; i++) begin
      if (cpu_valid) nc++;
      if (vid_valid) begin
        nv++;
        chk(rd_data == exp_byte(vid_addr), {req, " video byte"}, rd_data, exp_byte(vid_addr));
      end
      if (cpu_ce) ne++;
      @(negedge clk);
    end
    chk(nc == e_cpu, {req, " cpu slots"}, nc, e_cpu);
    chk(nv == e_vid, {req, " video slots"}, nv, e_vid);
    chk(ne == e_ce, {req, " cpu_ce pulses"}, ne, e_ce);
    cpu_req = 1'b0; vid_req = 1'b0;
    repeat (16) @(negedge clk);
  endtask

  task automatic t_stall_release();
    int n;
    @(negedge clk);
    mode = 2'd2; vid_req = 1'b1; cpu_req = 1'b1; cpu_addr = 16'h2222; cpu_rnw = 1'b1;
    n = 0;
    repeat (40) begin @(negedge clk); if (cpu_valid) n++; end
    chk(n == 0, "R8 cpu waits", n, 0);
    vid_req = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (!cpu_valid && n < 100);
    chk(n <= 16 && rd_data == exp_byte(16'h2222), "R9 cpu released", rd_data, exp_byte(16'h2222));
    cpu_req = 1'b0;
    repeat (16) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_read(16'h1234);
    t_read(16'hffff);
    t_write(16'h1234, 8'ha5);
    t_write(16'h00ff, 8'h3c);
    window(2'd0, 1'b1, 1'b1, 8, 0, 8, "R6");
    window(2'd1, 1'b1, 1'b1, 4, 4, 4, "R7");
    window(2'd1, 1'b1, 1'b0, 0, 4, 4, "R7 idle cpu");
    window(2'd2, 1'b1, 1'b1, 0, 8, 0, "R8");
    window(2'd3, 1'b1, 1'b1, 0, 8, 0, "R8 mode3");
    window(2'd1, 1'b0, 1'b1, 8, 0, 8, "R9");
    window(2'd2, 1'b0, 1'b0, 0, 0, 8, "R9 idle");
    t_stall_release();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule